// File: doc/BRIEF.md
# Play-out Sample Buffer with Occupancy Limiter

This block sits at the receive end of a packetised audio path. Packets of a fixed number of 16-bit signed samples (the packet length, M) arrive on the write side and are stored in arrival order. At each play-out instant the read side issues a request for some number of samples. That request normally comes from a rate estimator that compensates for clock skew between the two ends. The block does not pass that number on blindly. It grants a count chosen from the live number of stored, unclaimed samples. The buffer therefore cannot run dry, and it cannot drift upward past a ceiling of twice the packet length plus a run-time jitter reserve.

Every request is answered one cycle later with a granted count. The granted samples then stream out one per cycle in write order. Grants that arrive while earlier samples are still streaming are appended behind them. In normal operation the occupancy settles near one packet (plus the reserve, when one is set). This gives a fixed delay of about one packet period. If a packet arrives when the physical storage cannot take all of it, the whole packet is discarded and a one-cycle overflow pulse is raised.

Top module: `playout_fifo_limiter`

## Requirements
- R1: After a synchronous active-low reset, the buffer is empty, no grant, sample or overflow pulse is presented, and a request that follows grants 0.
- R2: Samples that are accepted leave on `out_data_o` unchanged and in the order they were written. A sample of a dropped packet never appears.
- R3: When the requested count N is greater than the unclaimed occupancy b, the grant is b.
- R4: When N is at most b and b is greater than the ceiling, the grant is b − M. The ceiling is 2M plus the effective reserve, and exactly M unclaimed samples remain afterwards.
- R5: When neither R3 nor R4 applies, the grant equals N.
- R6: b counts a sample written in the same cycle as the request. It does not count samples already granted to earlier requests.
- R7: `grant_valid_o` is high, with `grant_o`, in the cycle after each request. Granted samples follow back to back, one per cycle, starting the cycle after the grant, and later grants queue behind earlier ones.
- R8: A packet whose first sample (`wr_sop_i` high) arrives when the stored count plus M exceeds the physical depth is dropped in full. `ovf_o` pulses for the one cycle after that first sample.
- R9: A reserve on `reserve_i` above the MAX_RESERVE parameter is treated as MAX_RESERVE. The physical depth is 2M + MAX_RESERVE rounded up to a power of two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reserve_i | input | CW | Jitter reserve in samples, which raises the ceiling |
| wr_valid_i | input | 1 | A sample is presented on the write side |
| wr_sop_i | input | 1 | The presented sample is the first of a packet |
| wr_data_i | input | 16 | Incoming sample, signed |
| ovf_o | output | 1 | Pulse: a packet was dropped for lack of space |
| rd_req_i | input | 1 | Play-out instant, with a requested count |
| rd_count_i | input | CW | Requested count N |
| grant_valid_o | output | 1 | Grant is presented |
| grant_o | output | CW | Granted count |
| out_valid_o | output | 1 | A granted sample is presented |
| out_data_o | output | 16 | Outgoing sample, signed |

## Verification
A wrong unclaimed-occupancy count shows up as a wrong grant at the first request after the fault, because every grant rule compares against that count. A broken claim or pop count shows as a missing, extra or repeated sample in the stream right after a grant. A pointer fault shows as out-of-order data within one drain. An error in the space check shows as a missing or spurious overflow pulse one cycle after the first sample of a packet, and later as data that was never accepted.

// File: rtl/pfl_pkg.sv
// Shared types and helpers for the play-out buffer.
// Assumes samples are 16-bit two's complement.
package pfl_pkg;
    localparam int SAMPLE_W = 16;

    typedef logic signed [SAMPLE_W-1:0] sample_t;

    // Address bits needed to store two packets plus the largest reserve.
    function automatic int fifo_addr_bits(input int pkt_len, input int max_res);
        return $clog2(2 * pkt_len + max_res);
    endfunction
endpackage

// File: rtl/pfl_write_ctrl.sv
// Packet admission: decides, at the first sample of each packet, whether the
// whole packet fits in physical storage, and gates the remaining samples of
// that packet with the same decision.
// Assumes a packet is M samples presented after its start, possibly with gaps.
module pfl_write_ctrl #(
    parameter int PKT_LEN = 40,
    parameter int CW      = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid_i,
    input  logic          wr_sop_i,
    input  logic [CW-1:0] fill_i,
    output logic          wr_en_o,
    output logic          ovf_o
);
    localparam int PHYS = 1 << (CW - 1);

    logic fits;
    logic keep_q;

    // Space check against physical fill, one bit wider to avoid wrap.
    always_comb fits = ({1'b0, fill_i} + (CW+1)'(PKT_LEN)) <= (CW+1)'(PHYS);

    // Accept a start sample that fits, or a body sample of a kept packet.
    always_comb wr_en_o = wr_valid_i && (wr_sop_i ? fits : keep_q);

    // Remember the admission decision for the body of the packet.
    always_ff @(posedge clk) begin
        if (!rst_n)                    keep_q <= 1'b0;
        else if (wr_valid_i && wr_sop_i) keep_q <= fits;
    end

    // One-cycle pulse for each dropped packet.
    always_ff @(posedge clk) begin
        if (!rst_n) ovf_o <= 1'b0;
        else        ovf_o <= wr_valid_i && wr_sop_i && !fits;
    end
endmodule

// File: rtl/pfl_storage.sv
// Sample memory with wrap-bit pointers. Writes land at the write pointer and
// pops advance the read pointer. The fill is the pointer difference.
// Assumes callers never pop an empty store or write a full one.
module pfl_storage
    import pfl_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    wr_en_i,
    input  sample_t wr_data_i,
    input  logic    pop_i,
    output sample_t rd_data_o,
    output logic [AW:0] fill_o
);
    localparam int PHYS = 1 << AW;

    sample_t     mem [PHYS];
    logic [AW:0] wptr_q;
    logic [AW:0] rptr_q;

    // Store an accepted sample.
    always_ff @(posedge clk) begin
        if (wr_en_i) mem[wptr_q[AW-1:0]] <= wr_data_i;
    end

    // Advance the pointers on write and pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
        end else begin
            if (wr_en_i) wptr_q <= wptr_q + 1'b1;
            if (pop_i)   rptr_q <= rptr_q + 1'b1;
        end
    end

    // Head sample and occupied count.
    always_comb rd_data_o = mem[rptr_q[AW-1:0]];
    always_comb fill_o    = wptr_q - rptr_q;

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |-> fill_o < (AW+1)'(PHYS));

    // R2
    no_empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> fill_o != '0);
endmodule

// File: rtl/pfl_limiter.sv
// Occupancy limiter: turns a requested count into a granted count.
// The occupancy includes a sample written in the same cycle.
// Priority: an empty-out grant for over-asking, then a trim grant above the
// ceiling, else the request as given.
module pfl_limiter #(
    parameter int PKT_LEN     = 40,
    parameter int MAX_RESERVE = 80,
    parameter int CW          = 9
) (
    input  logic [CW-1:0] avail_i,
    input  logic          wr_en_i,
    input  logic [CW-1:0] req_count_i,
    input  logic [CW-1:0] reserve_i,
    output logic [CW-1:0] occ_o,
    output logic [CW-1:0] ub_o,
    output logic [CW-1:0] grant_o
);
    localparam logic [CW-1:0] PKT_C     = CW'(PKT_LEN);
    localparam logic [CW-1:0] RES_MAX_C = CW'(MAX_RESERVE);

    logic [CW-1:0] res_eff;

    // Clamp the reserve to what the storage was sized for.
    always_comb res_eff = (reserve_i > RES_MAX_C) ? RES_MAX_C : reserve_i;

    // Ceiling: two packets plus the reserve.
    always_comb ub_o = PKT_C + PKT_C + res_eff;

    // Unclaimed occupancy after this cycle's write.
    always_comb occ_o = avail_i + {{(CW-1){1'b0}}, wr_en_i};

    // Grant selection in priority order.
    always_comb begin
        if (req_count_i > occ_o)  grant_o = occ_o;
        else if (occ_o > ub_o)    grant_o = occ_o - PKT_C;
        else                      grant_o = req_count_i;
    end
endmodule

// File: rtl/pfl_drain.sv
// Drain sequencer: registers each grant, keeps the unclaimed count, and
// streams claimed samples one per cycle. New claims queue behind old ones.
// Assumes grant_i never exceeds occ_i.
module pfl_drain
    import pfl_pkg::*;
#(
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_req_i,
    input  logic [CW-1:0] grant_i,
    input  logic [CW-1:0] occ_i,
    input  logic [CW-1:0] ub_i,
    input  logic [CW-1:0] fill_i,
    input  sample_t       rd_data_i,
    output logic          pop_o,
    output logic [CW-1:0] avail_o,
    output logic          grant_valid_o,
    output logic [CW-1:0] grant_o,
    output logic          out_valid_o,
    output sample_t       out_data_o
);
    logic [CW-1:0] claim;
    logic [CW-1:0] rem_q;

    // Samples claimed by this cycle's request.
    always_comb claim = rd_req_i ? grant_i : '0;

    // Pop while claimed samples remain.
    always_comb pop_o = (rem_q != '0);

    // Unclaimed count and outstanding claims.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            avail_o <= '0;
            rem_q   <= '0;
        end else begin
            avail_o <= occ_i - claim;
            rem_q   <= rem_q - {{(CW-1){1'b0}}, pop_o} + claim;
        end
    end

    // Grant report, one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_valid_o <= 1'b0;
            grant_o       <= '0;
        end else begin
            grant_valid_o <= rd_req_i;
            grant_o       <= claim;
        end
    end

    // Output sample register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_o <= 1'b0;
            out_data_o  <= '0;
        end else begin
            out_valid_o <= pop_o;
            if (pop_o) out_data_o <= rd_data_i;
        end
    end

    // R3
    grant_within_occ_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_i |-> grant_i <= occ_i);

    // R4
    avail_under_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_i |=> avail_o <= $past(ub_i));

    // R7
    claims_stored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rem_q <= fill_i);
endmodule

// File: rtl/playout_fifo_limiter.sv
// Top of the play-out buffer: admission, storage, limiter and drain.
// Assumes the reserve stays stable in any cycle with a request, and that
// packets are exactly PKT_LEN samples long.
module playout_fifo_limiter
    import pfl_pkg::*;
#(
    parameter int PKT_LEN     = 40,
    parameter int MAX_RESERVE = 80,
    localparam int AW         = pfl_pkg::fifo_addr_bits(PKT_LEN, MAX_RESERVE),
    localparam int CW         = AW + 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [CW-1:0]              reserve_i,
    input  logic                       wr_valid_i,
    input  logic                       wr_sop_i,
    input  logic signed [SAMPLE_W-1:0] wr_data_i,
    output logic                       ovf_o,
    input  logic                       rd_req_i,
    input  logic [CW-1:0]              rd_count_i,
    output logic                       grant_valid_o,
    output logic [CW-1:0]              grant_o,
    output logic                       out_valid_o,
    output logic signed [SAMPLE_W-1:0] out_data_o
);
    logic          wr_en;
    logic          pop;
    sample_t       rd_data;
    logic [CW-1:0] fill;
    logic [CW-1:0] avail;
    logic [CW-1:0] occ;
    logic [CW-1:0] ub;
    logic [CW-1:0] grant;

    pfl_write_ctrl #(.PKT_LEN(PKT_LEN), .CW(CW)) u_wr (
        .clk(clk), .rst_n(rst_n), .wr_valid_i(wr_valid_i), .wr_sop_i(wr_sop_i),
        .fill_i(fill), .wr_en_o(wr_en), .ovf_o(ovf_o)
    );

    pfl_storage #(.AW(AW)) u_mem (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data_i),
        .pop_i(pop), .rd_data_o(rd_data), .fill_o(fill)
    );

    pfl_limiter #(.PKT_LEN(PKT_LEN), .MAX_RESERVE(MAX_RESERVE), .CW(CW)) u_lim (
        .avail_i(avail), .wr_en_i(wr_en), .req_count_i(rd_count_i),
        .reserve_i(reserve_i), .occ_o(occ), .ub_o(ub), .grant_o(grant)
    );

    pfl_drain #(.CW(CW)) u_drn (
        .clk(clk), .rst_n(rst_n), .rd_req_i(rd_req_i), .grant_i(grant),
        .occ_i(occ), .ub_i(ub), .fill_i(fill), .rd_data_i(rd_data),
        .pop_o(pop), .avail_o(avail), .grant_valid_o(grant_valid_o),
        .grant_o(grant_o), .out_valid_o(out_valid_o), .out_data_o(out_data_o)
    );

    // R8
    drop_keeps_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> fill <= $past(fill));

    // R6
    unclaimed_within_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        avail <= fill);
endmodule

// File: tb/playout_fifo_limiter_tb.sv
module playout_fifo_limiter_tb;
    localparam int M     = 4;
    localparam int MAXR  = 8;
    localparam int AW    = $clog2(2 * M + MAXR);
    localparam int CW    = AW + 1;
    localparam int PHYS  = 1 << AW;
    localparam int ITERS = 1800;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [CW-1:0]       reserve_i = '0;
    logic                wr_valid_i = 1'b0;
    logic                wr_sop_i = 1'b0;
    logic signed [15:0]  wr_data_i = '0;
    logic                ovf_o;
    logic                rd_req_i = 1'b0;
    logic [CW-1:0]       rd_count_i = '0;
    logic                grant_valid_o;
    logic [CW-1:0]       grant_o;
    logic                out_valid_o;
    logic signed [15:0]  out_data_o;

    playout_fifo_limiter #(.PKT_LEN(M), .MAX_RESERVE(MAXR)) u_dut (
        .clk(clk), .rst_n(rst_n), .reserve_i(reserve_i),
        .wr_valid_i(wr_valid_i), .wr_sop_i(wr_sop_i), .wr_data_i(wr_data_i),
        .ovf_o(ovf_o), .rd_req_i(rd_req_i), .rd_count_i(rd_count_i),
        .grant_valid_o(grant_valid_o), .grant_o(grant_o),
        .out_valid_o(out_valid_o), .out_data_o(out_data_o)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic signed [15:0] q[$];
    int avail_m;
    int rem_m;
    bit keep_m;
    int pkt_pos;
    int seed;
    logic signed [15:0] next_val;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int rnd();
        seed = seed * 1103515245 + 12345;
        return (seed >>> 8) & 32'h7fff;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_valid_i = 0; wr_sop_i = 0; rd_req_i = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        q.delete(); avail_m = 0; rem_m = 0; keep_m = 0; pkt_pos = 0;
        #1;
        // R1: reset state at the ports
        chk(!grant_valid_o, "R1 grant_valid after reset", int'(grant_valid_o), 0);
        chk(!out_valid_o, "R1 out_valid after reset", int'(out_valid_o), 0);
        chk(!ovf_o, "R1 ovf after reset", int'(ovf_o), 0);
    endtask

    // One cycle: drive inputs, predict, clock, compare.
    task automatic step(input bit wv, input bit sop, input bit rq, input int n, input int res);
        bit wr_acc, fits, ovf_e, pop_e;
        int b, ub, g, reff;
        string tag;
        logic signed [15:0] head;
        wr_valid_i = wv; wr_sop_i = sop; wr_data_i = next_val;
        rd_req_i = rq; rd_count_i = CW'(n); reserve_i = CW'(res);
        fits   = (q.size() + M) <= PHYS;
        wr_acc = wv && (sop ? fits : keep_m);
        ovf_e  = wv && sop && !fits;
        reff   = (res > MAXR) ? MAXR : res;
        ub     = 2 * M + reff;
        b      = avail_m + (wr_acc ? 1 : 0);
        if (n > b)       begin g = b;     tag = "R3"; end
        else if (b > ub) begin g = b - M; tag = "R4"; end
        else             begin g = n;     tag = "R5"; end
        if (rq && wr_acc)   tag = {tag, "/R6"};
        if (rq && res > MAXR) tag = {tag, "/R9"};
        pop_e = rem_m > 0;
        head  = pop_e ? q[0] : '0;
        @(posedge clk);
        #1;
        chk(grant_valid_o == rq, "R7 grant_valid", int'(grant_valid_o), int'(rq));
        if (rq) chk(int'(grant_o) == g, {tag, " grant"}, int'(grant_o), g);
        chk(ovf_o == ovf_e, "R8 ovf pulse", int'(ovf_o), int'(ovf_e));
        chk(out_valid_o == pop_e, "R7 out_valid", int'(out_valid_o), int'(pop_e));
        if (pop_e) chk(out_data_o == head, "R2 sample order", int'(out_data_o), int'(head));
        if (pop_e) void'(q.pop_front());
        if (wr_acc) q.push_back(next_val);
        if (wv && sop) keep_m = fits;
        if (wv) next_val = next_val + 16'sd1;
        avail_m = b - (rq ? g : 0);
        rem_m   = rem_m - (pop_e ? 1 : 0) + (rq ? g : 0);
        @(negedge clk);
    endtask

    initial begin
        int reserves[4] = '{0, 4, 8, 13};
        seed = 7;
        next_val = -16'sd300;
        for (int r = 0; r < 4; r++) begin
            do_reset();
            @(negedge clk);
            // R1: first request after reset grants nothing
            step(1'b0, 1'b0, 1'b1, 5, reserves[r]);
            for (int it = 0; it < ITERS; it++) begin
                int phase, pw, pr, n;
                bit wv, sop, rq;
                phase = (it / 200) % 3;
                pw = (phase == 0) ? 2 : (phase == 1) ? 6 : 14;
                pr = (phase == 0) ? 10 : (phase == 1) ? 5 : 3;
                wv = 0; sop = 0;
                if (pkt_pos > 0 && pkt_pos < M) begin
                    if ((rnd() % 4) != 0) begin wv = 1; pkt_pos++; end
                end else if ((rnd() % pw) == 0) begin
                    wv = 1; sop = 1; pkt_pos = 1;
                end
                rq = (rnd() % pr) == 0;
                n  = rnd() % (PHYS + 4);
                step(wv, sop, rq, n, reserves[r]);
            end
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule